// File: doc/BRIEF.md
# Logic and Compare Flag Unit

This block takes the accumulator value and one 8-bit operand and performs one of four operations, chosen by a 2-bit select: bitwise AND, bitwise XOR, bitwise OR, or compare. It produces a result byte, a write enable for the accumulator, and a complete flag byte. Result, enable and flags are all registered, so they appear one clock after the inputs are presented.

The three logical operations write their result back to the accumulator. They share one flag path: sign, zero and even parity are taken from the result, and both subtract and carry are cleared. The only flag that differs between them is half-carry, which AND sets and which OR and XOR clear.

Compare subtracts the operand from the accumulator with no borrow-in. It keeps the flags of that subtraction and throws the difference away. During a compare the accumulator write enable stays low and the result port carries the accumulator value unchanged. The two undocumented flag bits, X and Y, are copied from the operand during a compare, not from the difference.

Top module: `logic_cmp_unit`

## Requirements
- R1: While rst_ni is low, res_o, acc_we_o and flags_o are all zero.
- R2: With op_i = 0 (AND), res_o is acc_i AND opnd_i, acc_we_o is 1, and H (flag bit 4) is 1.
- R3: With op_i = 1 (XOR) or op_i = 2 (OR), res_o is the matching bitwise result, acc_we_o is 1, and H (flag bit 4) is 0.
- R4: For the logical operations, S (bit 7) is res_o bit 7, Z (bit 6) is 1 exactly when res_o is zero, P/V (bit 2) is 1 when res_o has an even number of set bits, and N (bit 1) and C (bit 0) are 0.
- R5: For the logical operations, Y (bit 5) equals res_o bit 5 and X (bit 3) equals res_o bit 3.
- R6: With op_i = 3 (compare), acc_we_o is 0 and res_o equals acc_i.
- R7: For compare, with D = acc_i - opnd_i mod 256, S is D bit 7, Z is 1 when D is zero, and N is 1.
- R8: For compare, C is 1 when acc_i < opnd_i (unsigned), and H is 1 when acc_i[3:0] < opnd_i[3:0].
- R9: For compare, P/V is 1 on signed overflow: acc_i and opnd_i have different bit 7, and D bit 7 differs from acc_i bit 7.
- R10: For compare, Y is opnd_i bit 5 and X is opnd_i bit 3, whatever D is.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation select: 0 AND, 1 XOR, 2 OR, 3 compare |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand |
| res_o | output | 8 | Result (accumulator value during a compare) |
| acc_we_o | output | 1 | Accumulator write enable |
| flags_o | output | 8 | Flags: S,Z,Y,H,X,P/V,N,C from bit 7 down to bit 0 |

## Verification
The case that is hardest to reach is a compare in which X and Y differ between the operand and the difference. A zero difference also has to carry non-zero X/Y bits, so that X/Y taken from the operand can be told apart from X/Y taken from the difference. The vector table therefore includes an equal-operand compare with operand 0x28 and a compare whose difference has bit 5 set while the operand has it clear. Signed overflow is reached in both directions with the pairs 0x80/0x01 and 0x7F/0xFF. A directed test then drives new inputs just before an edge and checks that the outputs still show the previous operation.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_XOR = 2'd1,
    OP_OR  = 2'd2,
    OP_CMP = 2'd3
  } lcu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } lcu_flags_t;

  localparam int unsigned X_BIT = 3;
  localparam int unsigned Y_BIT = 5;
  localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/lcu_logic.sv
module lcu_logic #(
  parameter int unsigned W = 8
) (
  input  lcu_pkg::lcu_op_e op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     res_o
);
  import lcu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/lcu_sub.sv
module lcu_sub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o,
  output logic         half_o,
  output logic         ovf_o
);
  import lcu_pkg::*;
  localparam int unsigned MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide     = {1'b0, a_i} - {1'b0, b_i};
    diff_o   = wide[W-1:0];
    borrow_o = wide[W];
    half_o   = a_i[NIB_W-1:0] < b_i[NIB_W-1:0];
    ovf_o    = (a_i[MSB] ^ b_i[MSB]) & (wide[MSB] ^ a_i[MSB]);
  end

  // R8
  always_comb begin
    borrow_chk: assert (borrow_o == (a_i < b_i));
  end
endmodule

// File: rtl/lcu_flags.sv
module lcu_flags #(
  parameter int unsigned W = 8
) (
  input  lcu_pkg::lcu_op_e   op_i,
  input  logic [W-1:0]       acc_i,
  input  logic [W-1:0]       log_res_i,
  input  logic [W-1:0]       diff_i,
  input  logic               borrow_i,
  input  logic               half_i,
  input  logic               ovf_i,
  input  logic [1:0]         opnd_xy_i,  // {bit 5, bit 3} of operand
  output logic [W-1:0]       res_o,
  output logic               we_o,
  output lcu_pkg::lcu_flags_t flags_o
);
  import lcu_pkg::*;
  localparam int unsigned MSB = W - 1;

  logic is_cmp;
  assign is_cmp = (op_i == OP_CMP);

  always_comb begin
    flags_o = '0;
    if (is_cmp) begin
      res_o      = acc_i;
      we_o       = 1'b0;
      flags_o.s  = diff_i[MSB];
      flags_o.z  = (diff_i == '0);
      flags_o.y  = opnd_xy_i[1];
      flags_o.h  = half_i;
      flags_o.x  = opnd_xy_i[0];
      flags_o.pv = ovf_i;
      flags_o.n  = 1'b1;
      flags_o.c  = borrow_i;
    end else begin
      res_o      = log_res_i;
      we_o       = 1'b1;
      flags_o.s  = log_res_i[MSB];
      flags_o.z  = (log_res_i == '0);
      flags_o.y  = log_res_i[Y_BIT];
      flags_o.h  = (op_i == OP_AND);
      flags_o.x  = log_res_i[X_BIT];
      flags_o.pv = ~^log_res_i;
      flags_o.n  = 1'b0;
      flags_o.c  = 1'b0;
    end
  end
endmodule

// File: rtl/logic_cmp_unit.sv
module logic_cmp_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] res_o,
  output logic         acc_we_o,
  output logic [7:0]   flags_o
);
  import lcu_pkg::*;

  lcu_op_e    op;
  logic [W-1:0] log_res, diff, res_d;
  logic         borrow, half, ovf, we_d;
  lcu_flags_t   flags_d;

  assign op = lcu_op_e'(op_i);

  lcu_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .res_o(log_res)
  );

  lcu_sub #(.W(W)) u_sub (
    .a_i(acc_i), .b_i(opnd_i), .diff_o(diff),
    .borrow_o(borrow), .half_o(half), .ovf_o(ovf)
  );

  lcu_flags #(.W(W)) u_flags (
    .op_i(op), .acc_i(acc_i), .log_res_i(log_res), .diff_i(diff),
    .borrow_i(borrow), .half_i(half), .ovf_i(ovf),
    .opnd_xy_i({opnd_i[Y_BIT], opnd_i[X_BIT]}),
    .res_o(res_d), .we_o(we_d), .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      acc_we_o <= 1'b0;
      flags_o  <= '0;
    end else begin
      res_o    <= res_d;
      acc_we_o <= we_d;
      flags_o  <= flags_d;
    end
  end

  // R4
  logic_nc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> (!flags_o[1] && !flags_o[0] && flags_o[6] == (res_o == '0)));

  // R5
  logic_xy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> (flags_o[5] == res_o[Y_BIT] && flags_o[3] == res_o[X_BIT]));

  // R2
  and_h_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_AND) |-> (acc_we_o && flags_o[4]));

  // R6
  cmp_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_CMP) |-> (!acc_we_o && flags_o[1] && res_o == $past(acc_i)));

  // R10
  cmp_xy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == OP_CMP) |->
      (flags_o[5] == $past(opnd_i[Y_BIT]) && flags_o[3] == $past(opnd_i[X_BIT])));
endmodule

// File: tb/sim_logic_cmp_unit.sv
module sim_logic_cmp_unit;
  localparam time CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       we;
    logic [7:0] fl;
  } vec_t;

  // flags: S Z Y H X P N C
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'hF0, 8'h3C, 8'h30, 1'b1, 8'h34}, // R2 AND, Y from result
    '{2'd1, 8'hFF, 8'hFF, 8'h00, 1'b1, 8'h44}, // R3 XOR zero
    '{2'd2, 8'h80, 8'h08, 8'h88, 1'b1, 8'h8C}, // R3 OR sign, X
    '{2'd0, 8'h00, 8'hFF, 8'h00, 1'b1, 8'h54}, // R2 AND zero, H set
    '{2'd1, 8'hA5, 8'h0F, 8'hAA, 1'b1, 8'hAC}, // R5 XOR X and Y
    '{2'd2, 8'h01, 8'h02, 8'h03, 1'b1, 8'h04}, // R4 even parity
    '{2'd2, 8'h07, 8'h00, 8'h07, 1'b1, 8'h00}, // R4 odd parity
    '{2'd3, 8'h10, 8'h10, 8'h10, 1'b0, 8'h42}, // R7 equal
    '{2'd3, 8'h00, 8'h01, 8'h00, 1'b0, 8'h93}, // R8 borrow and half
    '{2'd3, 8'h80, 8'h01, 8'h80, 1'b0, 8'h16}, // R9 overflow neg-pos
    '{2'd3, 8'h7F, 8'hFF, 8'h7F, 1'b0, 8'hAF}, // R9 overflow pos-neg
    '{2'd3, 8'h28, 8'h28, 8'h28, 1'b0, 8'h6A}, // R10 XY from operand, D=0
    '{2'd3, 8'h3A, 8'h05, 8'h3A, 1'b0, 8'h02}  // R10 D bit5 set, operand clear
  };

  logic       clk = 0;
  logic       rst_ni = 0;
  logic [1:0] op_i = 0;
  logic [7:0] acc_i = 0, opnd_i = 0;
  logic [7:0] res_o, flags_o;
  logic       acc_we_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_cmp_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .res_o(res_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    op_i = 2'd0; acc_i = 8'hFF; opnd_i = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 res", res_o, 8'h00);
    chk("R1 we", {7'd0, acc_we_o}, 8'h00);
    chk("R1 flags", flags_o, 8'h00);
    @(negedge clk);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VEC[i].op == 2'd3) ? "R6 R7 R8 R9 R10" : "R2 R3 R4 R5";
      apply(VEC[i].op, VEC[i].a, VEC[i].b);
      chk({tag, " res"}, res_o, VEC[i].res);
      chk({tag, " we"}, {7'd0, acc_we_o}, {7'd0, VEC[i].we});
      chk({tag, " flags"}, flags_o, VEC[i].fl);
    end

    // R11: new inputs before the edge leave outputs unchanged
    apply(2'd2, 8'h80, 8'h08);
    @(negedge clk);
    op_i = 2'd1; acc_i = 8'hFF; opnd_i = 8'hFF;
    #1;
    chk("R11 hold res", res_o, 8'h88);
    chk("R11 hold flags", flags_o, 8'h8C);
    @(posedge clk);
    #1;
    chk("R11 update res", res_o, 8'h00);
    chk("R11 update flags", flags_o, 8'h44);

    // R6: compare after a logical op keeps accumulator value on res_o
    apply(2'd3, 8'hC3, 8'hC3);
    chk("R6 cmp we", {7'd0, acc_we_o}, 8'h00);
    chk("R6 cmp res", res_o, 8'hC3);
    chk("R7 cmp flags", flags_o, 8'h42);

    // R1: reset in mid-run clears outputs asynchronously
    apply(2'd0, 8'hFF, 8'hFF);
    @(negedge clk);
    rst_ni = 0;
    #1;
    chk("R1 mid res", res_o, 8'h00);
    chk("R1 mid flags", flags_o, 8'h00);
    chk("R1 mid we", {7'd0, acc_we_o}, 8'h00);

    finish_run();
  end
endmodule